// File: doc/BRIEF.md
# Parallel Panel Write Engine

This block streams pixel words to a command-mode LCD panel over an 8080-style parallel write bus. Pixel words arrive on a valid/ready stream. For each word the block drives an active-low chip select, an active-low write strobe and a data bus. The width of each phase of a write cycle comes from software-programmed fields.

Software sets up the phase timing, the interface enable and a pixel count through a small register write port. It then issues a one-shot trigger. The engine moves exactly that many words and then raises a sticky frame-done flag, which can also drive an interrupt line. The flag is cleared by writing one to it. The engine ignores any trigger that arrives while a frame is in flight, so that repeated triggers cannot disturb the panel.

Top module: `panel_wr_engine`

## Requirements
- R1: After reset, register 0 reads 0x0000_0100, and registers 1, 2 and 3 read 0. In the same state `lcd_cs_n` and `lcd_wr_n` are 1, and `px_ready` and `irq` are 0. Reads return the register selected by `reg_rd_addr` one clock later.
- R2: Register 0 holds the timing. It has chip-select setup in bits 19:16, strobe setup in bits 15:12, strobe active in bits 11:8, strobe hold in bits 7:4 and interface enable in bit 0. Register 1 holds trigger mode in bit 0 and the trigger command in bit 1. A frame starts only when a write to register 1 sets the command bit while trigger mode is set and the interface is enabled. In every other case the bus stays idle, and the command is not kept for later.
- R3: The command bit clears itself. A read of register 1 after the trigger shows bit 1 at 0, with trigger mode kept.
- R4: For every word, chip select is low for cs_setup + wr_setup + 1 clocks before the strobe falls, plus one clock for each clock that stalls on a missing input word. After the strobe rises, chip select stays low for wr_hold clocks and then goes high for at least one clock before the next word. The strobe is never low while chip select is high.
- R5: The strobe stays low for wr_active clocks. A wr_active of 0 gives a strobe of one clock.
- R6: `px_ready` is high only in the last setup clock of a word. The word is taken at the clock edge where the strobe falls, and `lcd_data` holds that word unchanged until the next word is taken.
- R7: A frame moves exactly the number of words held in register 2, bits 15:0. A count of 0 finishes the frame without any chip-select activity.
- R8: A trigger written while a frame is in flight is discarded. No second frame follows.
- R9: Register 3 bit 0 is the frame-done status. It is set when the last word's chip select has risen and stays set until a write with bit 0 at 1 clears it. A write with bit 0 at 0 leaves it unchanged.
- R10: Register 3 bit 1 is the interrupt enable. `irq` equals status AND enable, delayed by one clock.
- R11: The timing fields and the count are captured when a frame starts. Writes to them during a frame apply from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write select |
| reg_wr_data | input | REG_W | Register write data |
| reg_rd_addr | input | 2 | Register read select |
| reg_rd_data | output | REG_W | Registered read data |
| px_valid | input | 1 | Pixel word available |
| px_data | input | DATA_W | Pixel word |
| px_ready | output | 1 | Pixel word taken at this edge if valid |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| irq | output | 1 | Frame-done interrupt |

## Verification
A wrong phase counter shows up on the very word it affects. The setup, strobe or hold lengths measured on `lcd_cs_n` and `lcd_wr_n` are then off by a clock. A bad word count is seen at the end of the frame, as a mismatch between the words taken on the stream and the count written. A trigger guard that leaks shows up within a few hundred clocks of the frame end, as extra chip-select activity or a status bit that is set again after it was cleared. Faults in the status or interrupt path appear one clock after the frame ends, on `irq` and on a status read.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

  localparam int PH_W       = 4;
  localparam int PH_CNT_W   = PH_W + 1;
  localparam int REG_ADDR_W = 2;

  localparam int CS_LSB   = 16;
  localparam int WS_LSB   = 12;
  localparam int ACT_LSB  = 8;
  localparam int HOLD_LSB = 4;
  localparam int EN_BIT   = 0;

  localparam int TRIG_MODE_BIT = 0;
  localparam int TRIG_CMD_BIT  = 1;
  localparam int IRQ_STS_BIT   = 0;
  localparam int IRQ_EN_BIT    = 1;

  typedef struct packed {
    logic [PH_W-1:0] cs_setup;
    logic [PH_W-1:0] wr_setup;
    logic [PH_W-1:0] wr_active;
    logic [PH_W-1:0] wr_hold;
    logic            enable;
  } wr_timing_t;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_TIMING  = 2'd0,
    REG_TRIGGER = 2'd1,
    REG_COUNT   = 2'd2,
    REG_IRQ     = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_GAP    = 3'd4
  } eng_state_e;

endpackage

// File: rtl/panel_wr_regs.sv
module panel_wr_regs
  import panel_wr_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  busy,
  input  logic                  frame_done,
  output wr_timing_t            timing,
  output logic [CNT_W-1:0]      frame_len,
  output logic                  start,
  output logic                  sts,
  output logic                  irq_en
);

  logic       trig_mode;
  logic       trig_cmd;
  logic [REG_W-1:0] rd_word;
  reg_sel_e   wsel;
  reg_sel_e   rsel;
  logic       unused_wdata;

  assign wsel = reg_sel_e'(wr_addr);
  assign rsel = reg_sel_e'(rd_addr);
  assign unused_wdata = ^{wr_data[REG_W-1:CS_LSB+PH_W], wr_data[HOLD_LSB-1:2]};

  assign start = trig_cmd & trig_mode & timing.enable & ~busy;

  always_comb begin
    rd_word = '0;
    case (rsel)
      REG_TIMING: begin
        rd_word[CS_LSB+:PH_W]   = timing.cs_setup;
        rd_word[WS_LSB+:PH_W]   = timing.wr_setup;
        rd_word[ACT_LSB+:PH_W]  = timing.wr_active;
        rd_word[HOLD_LSB+:PH_W] = timing.wr_hold;
        rd_word[EN_BIT]         = timing.enable;
      end
      REG_TRIGGER: begin
        rd_word[TRIG_MODE_BIT] = trig_mode;
        rd_word[TRIG_CMD_BIT]  = trig_cmd;
      end
      REG_COUNT: rd_word[CNT_W-1:0] = frame_len;
      REG_IRQ: begin
        rd_word[IRQ_STS_BIT] = sts;
        rd_word[IRQ_EN_BIT]  = irq_en;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timing    <= '{cs_setup: '0, wr_setup: '0, wr_active: PH_W'(1),
                     wr_hold: '0, enable: 1'b0};
      trig_mode <= 1'b0;
      trig_cmd  <= 1'b0;
      frame_len <= '0;
      sts       <= 1'b0;
      irq_en    <= 1'b0;
      rd_data   <= '0;
    end else begin
      trig_cmd <= 1'b0;
      if (wr_en) begin
        case (wsel)
          REG_TIMING: begin
            timing.cs_setup  <= wr_data[CS_LSB+:PH_W];
            timing.wr_setup  <= wr_data[WS_LSB+:PH_W];
            timing.wr_active <= wr_data[ACT_LSB+:PH_W];
            timing.wr_hold   <= wr_data[HOLD_LSB+:PH_W];
            timing.enable    <= wr_data[EN_BIT];
          end
          REG_TRIGGER: begin
            trig_mode <= wr_data[TRIG_MODE_BIT];
            trig_cmd  <= wr_data[TRIG_CMD_BIT] & ~busy;
          end
          REG_COUNT: frame_len <= wr_data[CNT_W-1:0];
          REG_IRQ: begin
            irq_en <= wr_data[IRQ_EN_BIT];
            if (wr_data[IRQ_STS_BIT]) sts <= 1'b0;
          end
          default: ;
        endcase
      end
      if (frame_done) sts <= 1'b1;
      rd_data <= rd_word;
    end
  end

endmodule

// File: rtl/panel_wr_timing.sv
module panel_wr_timing
  import panel_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  wr_timing_t        timing,
  input  logic [CNT_W-1:0]  frame_len,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              busy,
  output logic              frame_done
);

  eng_state_e          state, st_n;
  logic [PH_CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0]    rem, rem_n;
  wr_timing_t          lat, lat_n;
  logic                take;
  logic [PH_CNT_W-1:0] setup_m1_new, setup_m1_lat, act_m1, hold_m1;
  logic                unused_lat;

  assign unused_lat = lat.enable;

  assign setup_m1_new = PH_CNT_W'(timing.cs_setup) + PH_CNT_W'(timing.wr_setup);
  assign setup_m1_lat = PH_CNT_W'(lat.cs_setup) + PH_CNT_W'(lat.wr_setup);
  assign act_m1  = (lat.wr_active == '0) ? '0 : PH_CNT_W'(lat.wr_active) - 1'b1;
  assign hold_m1 = PH_CNT_W'(lat.wr_hold) - 1'b1;

  assign in_ready   = (state == ST_SETUP) && (cnt == '0);
  assign take       = in_ready && in_valid;
  assign busy       = (state != ST_IDLE);
  assign frame_done = (state == ST_GAP) && (rem == '0);

  always_comb begin
    st_n  = state;
    cnt_n = cnt;
    rem_n = rem;
    lat_n = lat;
    case (state)
      ST_IDLE: begin
        if (start) begin
          lat_n = timing;
          rem_n = frame_len;
          cnt_n = setup_m1_new;
          st_n  = (frame_len == '0) ? ST_GAP : ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (in_valid) begin
          st_n  = ST_STROBE;
          cnt_n = act_m1;
          rem_n = rem - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt != '0) begin
          cnt_n = cnt - 1'b1;
        end else if (lat.wr_hold != '0) begin
          st_n  = ST_HOLD;
          cnt_n = hold_m1;
        end else begin
          st_n = ST_GAP;
        end
      end
      ST_HOLD: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else           st_n  = ST_GAP;
      end
      ST_GAP: begin
        if (rem == '0) begin
          st_n = ST_IDLE;
        end else begin
          st_n  = ST_SETUP;
          cnt_n = setup_m1_lat;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rem      <= '0;
      lat      <= '0;
      cs_n     <= 1'b1;
      wr_n     <= 1'b1;
      data_out <= '0;
    end else begin
      state <= st_n;
      cnt   <= cnt_n;
      rem   <= rem_n;
      lat   <= lat_n;
      cs_n  <= !((st_n == ST_SETUP) || (st_n == ST_STROBE) || (st_n == ST_HOLD));
      wr_n  <= !(st_n == ST_STROBE);
      if (take) data_out <= in_data;
    end
  end

endmodule

// File: rtl/panel_wr_engine.sv
module panel_wr_engine
  import panel_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic [REG_ADDR_W-1:0] reg_wr_addr,
  input  logic [REG_W-1:0]      reg_wr_data,
  input  logic [REG_ADDR_W-1:0] reg_rd_addr,
  output logic [REG_W-1:0]      reg_rd_data,
  input  logic                  px_valid,
  input  logic [DATA_W-1:0]     px_data,
  output logic                  px_ready,
  output logic                  lcd_cs_n,
  output logic                  lcd_wr_n,
  output logic [DATA_W-1:0]     lcd_data,
  output logic                  irq
);

  wr_timing_t       timing;
  logic [CNT_W-1:0] frame_len;
  logic             start;
  logic             busy;
  logic             frame_done;
  logic             sts;
  logic             irq_en;

  panel_wr_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .rd_addr    (reg_rd_addr),
    .rd_data    (reg_rd_data),
    .busy       (busy),
    .frame_done (frame_done),
    .timing     (timing),
    .frame_len  (frame_len),
    .start      (start),
    .sts        (sts),
    .irq_en     (irq_en)
  );

  panel_wr_timing #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_timing (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .timing     (timing),
    .frame_len  (frame_len),
    .in_valid   (px_valid),
    .in_data    (px_data),
    .in_ready   (px_ready),
    .cs_n       (lcd_cs_n),
    .wr_n       (lcd_wr_n),
    .data_out   (lcd_data),
    .busy       (busy),
    .frame_done (frame_done)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= sts & irq_en;
  end

endmodule

// File: rtl/panel_wr_engine_chk.sv
module panel_wr_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              wr_n,
  input logic              valid,
  input logic              ready,
  input logic [DATA_W-1:0] data,
  input logic              sts,
  input logic              irq_en,
  input logic              irq
);

  AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !cs_n); // R4

  AST_TAKE_THEN_FALL: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> $fell(wr_n)); // R6

  AST_FALL_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(valid && ready)); // R6

  AST_READY_IN_SETUP: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!cs_n && wr_n)); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(data) |-> $fell(wr_n)); // R6

  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sts) |-> (cs_n && wr_n)); // R9

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq == $past(sts && irq_en)); // R10

endmodule

bind panel_wr_engine panel_wr_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (lcd_cs_n),
  .wr_n   (lcd_wr_n),
  .valid  (px_valid),
  .ready  (px_ready),
  .data   (lcd_data),
  .sts    (sts),
  .irq_en (irq_en),
  .irq    (irq)
);

// File: tb/panel_wr_engine_bench.sv
module panel_wr_engine_bench;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int REG_W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [1:0]        reg_waddr = '0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [1:0]        reg_raddr = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready;
  logic              cs_n, wr_n;
  logic [DATA_W-1:0] data_out;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;

  int mon_pre, mon_act, mon_post, mon_stall, words, accepted, cs_low;
  bit seen_fall, prev_cs, hs_prev, data_bad;
  logic [DATA_W-1:0] last_acc;
  int e_L = 1, e_A = 1, e_H = 0;
  int c_cs, c_ws, c_act, c_hold;
  bit ie = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  panel_wr_engine #(.DATA_W(DATA_W), .CNT_W(16), .REG_W(REG_W)) u_panel_wr_engine (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_we), .reg_wr_addr(reg_waddr), .reg_wr_data(reg_wdata),
    .reg_rd_addr(reg_raddr), .reg_rd_data(reg_rdata),
    .px_valid(in_valid), .px_data(in_data), .px_ready(in_ready),
    .lcd_cs_n(cs_n), .lcd_wr_n(wr_n), .lcd_data(data_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input int cs, input int ws, input int act, input int hold, input bit en);
    cfg_word = {12'b0, cs[3:0], ws[3:0], act[3:0], hold[3:0], 3'b0, en};
  endfunction

  // Monitor and pixel source, both working at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      mon_pre = 0; mon_act = 0; mon_post = 0; mon_stall = 0;
      words = 0; accepted = 0; cs_low = 0;
      seen_fall = 0; prev_cs = 1; hs_prev = 0; data_bad = 0;
      last_acc = '0; in_valid = 1'b0;
    end else begin
      if (!cs_n) cs_low++;
      if (!wr_n) begin
        mon_act++; seen_fall = 1;
        if (data_out !== last_acc) data_bad = 1;
      end else if (!cs_n) begin
        if (seen_fall) begin
          mon_post++;
          if (data_out !== last_acc) data_bad = 1;
        end else mon_pre++;
      end else if (!prev_cs) begin
        chk(mon_pre == e_L + mon_stall, "R4 setup clocks before strobe", mon_pre, e_L + mon_stall);
        chk(mon_act == e_A, "R5 strobe width", mon_act, e_A);
        chk(mon_post == e_H, "R4 hold clocks", mon_post, e_H);
        chk(!data_bad, "R6 data held from take", {31'b0, data_bad}, 0);
        words++;
        mon_pre = 0; mon_act = 0; mon_post = 0; mon_stall = 0;
        seen_fall = 0; data_bad = 0;
      end
      prev_cs = cs_n;
      if (hs_prev || !in_valid) begin
        in_valid = ($urandom % 4) != 0;
        in_data  = DATA_W'($urandom);
      end
      hs_prev = in_valid && in_ready;
      if (hs_prev) begin
        last_acc = in_data; accepted++;
      end else if (in_ready) mon_stall++;
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_cfg(input int cs, input int ws, input int act, input int hold);
    c_cs = cs; c_ws = ws; c_act = act; c_hold = hold;
    wr_reg(2'd0, cfg_word(cs, ws, act, hold, 1'b1));
  endtask

  int acc0, words0;

  task automatic start_frame(input int n);
    e_L = c_cs + c_ws + 1;
    e_A = (c_act == 0) ? 1 : c_act;
    e_H = c_hold;
    acc0 = accepted; words0 = words;
    wr_reg(2'd2, n);
    wr_reg(2'd1, 32'h3);
  endtask

  task automatic finish_frame(input int n, input bit clr);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(2'd3, v);
      if (v[0]) break;
    end
    chk(v[0], "R9 status set at frame end", v, 1);
    chk(accepted - acc0 == n, "R7 words taken per frame", accepted - acc0, n);
    chk(words - words0 == n, "R7 strobes per frame", words - words0, n);
    if (clr) begin
      wr_reg(2'd3, {30'b0, ie, 1'b1});
      rd_reg(2'd3, v);
      chk(v[0] == 1'b0, "R9 status cleared by writing one", v, {30'b0, ie, 1'b0});
    end
  endtask

  task automatic run_frame(input int n);
    start_frame(n);
    finish_frame(n, 1'b1);
  endtask

  task automatic idle_cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0, c0;
    void'($urandom(32'd7741));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(cs_n && wr_n && !in_ready && !irq, "R1 idle outputs after reset",
        {cs_n, wr_n, in_ready, irq}, 4'b1100);
    rd_reg(2'd0, v); chk(v == 32'h100, "R1 timing reset value", v, 32'h100);
    rd_reg(2'd1, v); chk(v == 0, "R1 trigger reset value", v, 0);
    rd_reg(2'd2, v); chk(v == 0, "R1 count reset value", v, 0);
    rd_reg(2'd3, v); chk(v == 0, "R1 irq reset value", v, 0);

    // R2 interface disabled: trigger has no effect
    c_cs = 2; c_ws = 1; c_act = 3; c_hold = 1;
    wr_reg(2'd0, cfg_word(2, 1, 3, 1, 1'b0));
    wr_reg(2'd2, 2);
    a0 = accepted; c0 = cs_low;
    wr_reg(2'd1, 32'h3);
    idle_cycles(40);
    chk(accepted == a0 && cs_low == c0, "R2 disabled interface stays idle", cs_low - c0, 0);
    // R2 command without trigger mode
    wr_reg(2'd0, cfg_word(2, 1, 3, 1, 1'b1));
    wr_reg(2'd1, 32'h2);
    idle_cycles(40);
    chk(accepted == a0 && cs_low == c0, "R2 command without mode ignored", cs_low - c0, 0);
    wr_reg(2'd1, 32'h1);
    idle_cycles(40);
    chk(accepted == a0 && cs_low == c0, "R2 no stale command kept", cs_low - c0, 0);
    rd_reg(2'd3, v); chk(v[0] == 0, "R2 no status without frame", v, 0);

    // R3 self-clearing command, directed timing
    set_cfg(1, 2, 3, 1);
    start_frame(3);
    rd_reg(2'd1, v); chk(v == 32'h1, "R3 command bit self-clears", v, 1);
    finish_frame(3, 1'b1);

    // R5 zero active width, all-zero timing
    set_cfg(0, 0, 0, 0);
    run_frame(4);
    // largest timing values
    set_cfg(15, 15, 15, 15);
    run_frame(2);

    // R7 zero count
    set_cfg(1, 1, 1, 1);
    a0 = accepted; c0 = cs_low;
    run_frame(0);
    chk(cs_low == c0, "R7 zero count drives no select", cs_low - c0, 0);

    // R8 trigger while busy is discarded
    set_cfg(3, 3, 4, 2);
    start_frame(4);
    idle_cycles(10);
    wr_reg(2'd1, 32'h3);
    finish_frame(4, 1'b1);
    a0 = accepted; c0 = cs_low;
    idle_cycles(300);
    chk(accepted == a0 && cs_low == c0, "R8 no frame after busy trigger", cs_low - c0, 0);
    rd_reg(2'd3, v); chk(v[0] == 0, "R8 status stays clear", v, 0);

    // R11 timing captured at frame start
    set_cfg(2, 2, 2, 2);
    start_frame(4);
    idle_cycles(6);
    set_cfg(5, 0, 6, 0);
    wr_reg(2'd2, 9);
    finish_frame(4, 1'b1);
    run_frame(2);

    // R10 / R9 interrupt path
    ie = 1'b1;
    wr_reg(2'd3, 32'h2);
    run_frame(1);
    start_frame(1);
    finish_frame(1, 1'b0);
    idle_cycles(2);
    chk(irq == 1'b1, "R10 irq with status and enable", irq, 1);
    wr_reg(2'd3, 32'h2);
    rd_reg(2'd3, v); chk(v[0] == 1'b1, "R9 writing zero keeps status", v, 3);
    chk(irq == 1'b1, "R10 irq held while status set", irq, 1);
    wr_reg(2'd3, 32'h3);
    idle_cycles(2);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
    ie = 1'b0;
    wr_reg(2'd3, 32'h0);
    start_frame(1);
    finish_frame(1, 1'b0);
    idle_cycles(2);
    chk(irq == 1'b0, "R10 irq masked when disabled", irq, 0);
    wr_reg(2'd3, 32'h1);

    // random timing and counts
    for (int k = 0; k < 14; k++) begin
      set_cfg($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
      run_frame(1 + ($urandom % 5));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule